// File: doc/BRIEF.md
# Serial Digital Potentiometer Controller

This block is the digital control side of a 64-position potentiometer. A host drives it over a four-wire serial link (active-low chip select, serial clock, serial data in, serial data out). The block decodes commands framed by chip select and keeps a 6-bit wiper counter that sets the tap position, plus a small bank of 6-bit stored settings. The stored settings stand in for nonvolatile cells. Writing one of them raises a busy flag for a programmable number of system clocks.

The serial inputs are sampled by the system clock through synchronizers, so the serial clock must be several system clocks slow. A frame is at most three bytes. The first byte selects the device: a fixed type nibble and the strap address. The second byte holds a command and a register pointer. The optional third byte carries a value in or out. A dedicated command turns the rest of the frame into an up/down stepping mode, in which every serial clock pulse moves the wiper by one tap.

Top module: `dpot_ctrl`

## Requirements
- R1: During and after reset the wiper is 0, every stored setting is 0, busy is 0 and so_oe is 0.
- R2: A frame is ignored, with no register change and so_oe held low, when any of these holds: the upper nibble of byte 1 is not 0101; the lower four bits of byte 1 differ from dev_addr; or byte 2 is neither 8'h51 nor has its bits [1:0] equal to 00.
- R3: Byte 2 = 1010_0000, followed by a full data byte and a rising chip select, loads the wiper from the low six bits of the data byte (bits are sent MSB first on si and sampled on rising sck).
- R4: Byte 2 = 1100_pp00 with a full data byte writes stored setting pp. It then holds busy high for exactly BUSY_CYCLES system clocks.
- R5: Byte 2 = 1001_0000 makes the third byte on so equal to {2'b00, wiper}, MSB first. The MSB is valid before the first sck rise of that byte, and each later bit appears after an sck falling edge.
- R6: Byte 2 = 1011_pp00 returns {2'b00, setting pp} on so in the third byte.
- R7: A complete two-byte frame with byte 2 = 1101_pp00 copies setting pp into the wiper, without raising busy.
- R8: A complete two-byte frame with byte 2 = 1110_pp00 copies the wiper into setting pp and starts the busy period.
- R9: After byte 2 = 0010_0000, each sck rise with si high raises the wiper by one, and each with si low lowers it by one. This continues until chip select rises; the wiper saturates at 63 and at 0.
- R10: Byte 2 = 8'h51 returns 8'b0000000w on so, where w is the busy flag as it stood when byte 2 completed.
- R11: While busy is high, commands 1010, 1100, 1101 and 1110 change nothing, and the busy period is not restarted.
- R12: A frame whose chip select rises before its last required bit changes no register.
- R13: so_oe is high only during a read or status frame, from the end of byte 2 until chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data from host |
| dev_addr | input | ADDR_W | Strap address compared with byte 1 |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Drive enable for so (tri-state control) |
| wiper | output | VAL_W | Current wiper tap position |
| busy | output | 1 | Stored-setting write in progress |

## Verification
Some properties are checked by assertions on every cycle:
- the wiper moves only on a committed command or a step pulse, and a step moves it by exactly one tap with saturation;
- a command arriving while busy leaves all registers untouched;
- busy rises only on a commit;
- so holds between sck falling edges and is enabled only inside a frame.

Other behaviours can only be shown by the bench's scenarios: the byte-level decode of every opcode, that values are returned MSB first at the right bit slots, that mismatched or truncated frames are discarded, the exact length of the busy window, and saturation at both ends of the stepping mode.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   localparam logic [3:0] TYPE_ID     = 4'b0101;
   localparam logic [7:0] STATUS_BYTE = 8'h51;

   localparam logic [3:0] OP_STEP   = 4'b0010;
   localparam logic [3:0] OP_RD_WCR = 4'b1001;
   localparam logic [3:0] OP_WR_WCR = 4'b1010;
   localparam logic [3:0] OP_RD_DR  = 4'b1011;
   localparam logic [3:0] OP_WR_DR  = 4'b1100;
   localparam logic [3:0] OP_DR2W   = 4'b1101;
   localparam logic [3:0] OP_W2DR   = 4'b1110;

   typedef enum logic [2:0] {
      CMD_NONE, CMD_WR_WCR, CMD_WR_DR, CMD_DR2W, CMD_W2DR
   } cmd_e;

   typedef enum logic [2:0] {
      FS_IDLE, FS_ADDR, FS_INSTR, FS_DATA_IN,
      FS_DATA_OUT, FS_READY, FS_STEP, FS_SKIP
   } fstate_e;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("dpot_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dpot_frame.sv
module dpot_frame
   import dpot_pkg::*;
#(
   parameter int VAL_W  = 6,
   parameter int NUM_DR = 4,
   parameter int ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n_s,
   input  logic                    sck_s,
   input  logic                    si_s,
   input  logic [ADDR_W-1:0]       dev_addr,
   input  logic [VAL_W-1:0]        wcr,
   input  logic [NUM_DR*VAL_W-1:0] dr_flat,
   input  logic                    busy,
   output logic                    cmd_valid,
   output cmd_e                    cmd_kind,
   output logic [1:0]              cmd_ptr,
   output logic [VAL_W-1:0]        cmd_data,
   output logic                    step_up,
   output logic                    step_dn,
   output logic                    so,
   output logic                    so_oe
);
   fstate_e          state;
   logic             cs_q, sck_q;
   logic             cs_fall, cs_rise, sck_rise, sck_fall;
   logic [2:0]       bit_cnt;
   logic [7:0]       sh, out_sr, byte_in;
   logic             byte_done, armed;
   cmd_e             lat_kind;
   logic [1:0]       lat_ptr;
   logic [VAL_W-1:0] lat_data;

   fstate_e          dec_state;
   cmd_e             dec_kind;
   logic [7:0]       dec_out;
   logic [3:0]       op;
   logic [1:0]       ptr;
   logic             ptr_ok, low_ok;

   function automatic logic [7:0] pad(input logic [VAL_W-1:0] v);
      logic [7:0] r;
      r = '0;
      r[VAL_W-1:0] = v;
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_n_s;
         sck_q <= sck_s;
      end
   end

   assign cs_fall   = cs_q & ~cs_n_s;
   assign cs_rise   = ~cs_q & cs_n_s;
   assign sck_rise  = ~sck_q & sck_s & ~cs_n_s;
   assign sck_fall  = sck_q & ~sck_s & ~cs_n_s;
   assign byte_in   = {sh[6:0], si_s};
   assign byte_done = sck_rise && (bit_cnt == 3'd7);

   // command byte decode, evaluated on the bit that completes byte 2
   assign op     = byte_in[7:4];
   assign ptr    = byte_in[3:2];
   assign ptr_ok = int'(ptr) < NUM_DR;
   assign low_ok = (byte_in[1:0] == 2'b00);

   always_comb begin
      dec_state = FS_SKIP;
      dec_kind  = CMD_NONE;
      dec_out   = '0;
      if (byte_in == STATUS_BYTE) begin
         dec_state = FS_DATA_OUT;
         dec_out   = {7'd0, busy};
      end else if (low_ok && ptr_ok) begin
         case (op)
            OP_RD_WCR: begin
               dec_state = FS_DATA_OUT;
               dec_out   = pad(wcr);
            end
            OP_RD_DR: begin
               dec_state = FS_DATA_OUT;
               dec_out   = pad(dr_flat[int'(ptr)*VAL_W +: VAL_W]);
            end
            OP_WR_WCR: begin
               dec_state = FS_DATA_IN;
               dec_kind  = CMD_WR_WCR;
            end
            OP_WR_DR: begin
               dec_state = FS_DATA_IN;
               dec_kind  = CMD_WR_DR;
            end
            OP_DR2W: begin
               dec_state = FS_READY;
               dec_kind  = CMD_DR2W;
            end
            OP_W2DR: begin
               dec_state = FS_READY;
               dec_kind  = CMD_W2DR;
            end
            OP_STEP: begin
               if (ptr == 2'b00) dec_state = FS_STEP;
            end
            default: dec_state = FS_SKIP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FS_IDLE;
         bit_cnt  <= '0;
         sh       <= '0;
         out_sr   <= '0;
         armed    <= 1'b0;
         lat_kind <= CMD_NONE;
         lat_ptr  <= '0;
         lat_data <= '0;
      end else if (cs_rise) begin
         state <= FS_IDLE;
         armed <= 1'b0;
      end else if (cs_fall) begin
         state   <= FS_ADDR;
         bit_cnt <= '0;
         armed   <= 1'b0;
      end else begin
         if (sck_rise) begin
            sh      <= byte_in;
            bit_cnt <= bit_cnt + 3'd1;
         end
         case (state)
            FS_ADDR: begin
               if (byte_done) begin
                  if (byte_in[7:4] == TYPE_ID && byte_in[ADDR_W-1:0] == dev_addr)
                     state <= FS_INSTR;
                  else
                     state <= FS_SKIP;
               end
            end
            FS_INSTR: begin
               if (byte_done) begin
                  state    <= dec_state;
                  lat_kind <= dec_kind;
                  lat_ptr  <= ptr;
                  out_sr   <= dec_out;
                  armed    <= 1'b0;
               end
            end
            FS_DATA_IN: begin
               if (byte_done) begin
                  state    <= FS_READY;
                  lat_data <= byte_in[VAL_W-1:0];
               end
            end
            FS_DATA_OUT: begin
               if (sck_rise) armed <= 1'b1;
               if (sck_fall && armed) out_sr <= {out_sr[6:0], 1'b0};
            end
            default: ;
         endcase
      end
   end

   assign cmd_valid = cs_rise && (state == FS_READY);
   assign cmd_kind  = lat_kind;
   assign cmd_ptr   = lat_ptr;
   assign cmd_data  = lat_data;
   assign step_up   = (state == FS_STEP) && sck_rise && si_s;
   assign step_dn   = (state == FS_STEP) && sck_rise && !si_s;
   assign so        = out_sr[7];
   assign so_oe     = (state == FS_DATA_OUT);

   // R13: read data is only driven inside an open frame
   a_r13_oe_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> !cs_q);

   // R5: serial output moves only after a serial clock falling edge
   a_r5_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
   import dpot_pkg::*;
#(
   parameter int VAL_W       = 6,
   parameter int NUM_DR      = 4,
   parameter int BUSY_CYCLES = 1000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  cmd_e                    cmd_kind,
   input  logic [1:0]              cmd_ptr,
   input  logic [VAL_W-1:0]        cmd_data,
   input  logic                    step_up,
   input  logic                    step_dn,
   output logic [VAL_W-1:0]        wcr,
   output logic [NUM_DR*VAL_W-1:0] dr_flat,
   output logic                    busy
);
   localparam int               CNT_W   = $clog2(BUSY_CYCLES + 1);
   localparam logic [VAL_W-1:0] MAX_VAL = {VAL_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_LD  = CNT_W'(BUSY_CYCLES);

   logic             accept, nv_start;
   logic [CNT_W-1:0] cnt;
   logic [VAL_W-1:0] dr_sel;

   assign accept   = cmd_valid && !busy;
   assign nv_start = accept && (cmd_kind == CMD_WR_DR || cmd_kind == CMD_W2DR);
   assign dr_sel   = dr_flat[int'(cmd_ptr)*VAL_W +: VAL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 wcr <= '0;
      else if (accept && cmd_kind == CMD_WR_WCR)  wcr <= cmd_data;
      else if (accept && cmd_kind == CMD_DR2W)    wcr <= dr_sel;
      else if (step_up && wcr != MAX_VAL)         wcr <= wcr + 1'b1;
      else if (step_dn && wcr != '0)              wcr <= wcr - 1'b1;
   end

   generate
      for (genvar i = 0; i < NUM_DR; i++) begin : g_dr
         logic [VAL_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (nv_start && int'(cmd_ptr) == i)
               q <= (cmd_kind == CMD_WR_DR) ? cmd_data : wcr;
         end
         assign dr_flat[i*VAL_W +: VAL_W] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (nv_start)   cnt <= CNT_LD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R1: everything held cleared while reset is applied
   always @(posedge clk) begin
      if (!rst_n) a_r1_cleared_in_reset: assert (wcr == '0 && cnt == '0 && dr_flat == '0);
   end

   // R9: one step per pulse, clamped at both ends
   a_r9_step_up_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      step_up |=> wcr == (($past(wcr) == MAX_VAL) ? MAX_VAL : $past(wcr) + 1'b1));
   a_r9_step_dn_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      step_dn |=> wcr == (($past(wcr) == '0) ? '0 : $past(wcr) - 1'b1));

   // R11: commands landing in the busy window leave state untouched
   a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> ($stable(wcr) && $stable(dr_flat)));

   // R4: busy window opens only on a committed command
   a_r4_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   // R12: wiper changes only after a commit or a step event
   a_r12_wcr_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cmd_valid) && !$past(step_up) && !$past(step_dn)) |-> $stable(wcr));
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
   import dpot_pkg::*;
#(
   parameter int VAL_W       = 6,
   parameter int NUM_DR      = 4,
   parameter int ADDR_W      = 4,
   parameter int BUSY_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              so,
   output logic              so_oe,
   output logic [VAL_W-1:0]  wiper,
   output logic              busy
);
   if (VAL_W < 1 || VAL_W > 8) begin : g_bad_val
      $error("dpot_ctrl: VAL_W must be 1..8");
   end
   if (NUM_DR < 1 || NUM_DR > 4) begin : g_bad_dr
      $error("dpot_ctrl: NUM_DR must be 1..4");
   end
   if (ADDR_W < 1 || ADDR_W > 4) begin : g_bad_addr
      $error("dpot_ctrl: ADDR_W must be 1..4");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("dpot_ctrl: BUSY_CYCLES must be positive");
   end

   logic                    cs_s, sck_s, si_s;
   logic                    cmd_valid, step_up, step_dn;
   cmd_e                    cmd_kind;
   logic [1:0]              cmd_ptr;
   logic [VAL_W-1:0]        cmd_data, wcr;
   logic [NUM_DR*VAL_W-1:0] dr_flat;

   dpot_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, si}),
      .q     ({cs_s, sck_s, si_s})
   );

   dpot_frame #(.VAL_W(VAL_W), .NUM_DR(NUM_DR), .ADDR_W(ADDR_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (cs_s),
      .sck_s     (sck_s),
      .si_s      (si_s),
      .dev_addr  (dev_addr),
      .wcr       (wcr),
      .dr_flat   (dr_flat),
      .busy      (busy),
      .cmd_valid (cmd_valid),
      .cmd_kind  (cmd_kind),
      .cmd_ptr   (cmd_ptr),
      .cmd_data  (cmd_data),
      .step_up   (step_up),
      .step_dn   (step_dn),
      .so        (so),
      .so_oe     (so_oe)
   );

   dpot_regs #(.VAL_W(VAL_W), .NUM_DR(NUM_DR), .BUSY_CYCLES(BUSY_CYCLES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_kind  (cmd_kind),
      .cmd_ptr   (cmd_ptr),
      .cmd_data  (cmd_data),
      .step_up   (step_up),
      .step_dn   (step_dn),
      .wcr       (wcr),
      .dr_flat   (dr_flat),
      .busy      (busy)
   );

   assign wiper = wcr;
endmodule

// File: tb/dpot_ctrl_tb.sv
`timescale 1ns/1ps
module dpot_ctrl_tb;
   localparam int BUSY = 2500;
   localparam int HP   = 8;

   typedef struct packed {
      logic [23:0] frm;
      logic [4:0]  nbits;
      logic        chk_rd;
      logic [7:0]  exp_rd;
      logic [5:0]  exp_w;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{24'h5AB000, 5'd24, 1'b1, 8'h00, 6'd0,  4'd6},  // R6 and R1: setting 0 reads 0
      '{24'h5AA02A, 5'd24, 1'b0, 8'h00, 6'd42, 4'd3},  // R3 write wiper
      '{24'h5A9000, 5'd24, 1'b1, 8'h2A, 6'd42, 4'd5},  // R5 read wiper
      '{24'h5AC815, 5'd24, 1'b0, 8'h00, 6'd42, 4'd4},  // R4 write setting 2
      '{24'h5AB800, 5'd24, 1'b1, 8'h15, 6'd42, 4'd6},  // R6 read setting 2
      '{24'h5AD800, 5'd16, 1'b0, 8'h00, 6'd21, 4'd7},  // R7 setting 2 -> wiper
      '{24'h5AA0FF, 5'd24, 1'b0, 8'h00, 6'd63, 4'd3},  // R3 low six bits only
      '{24'h5AE400, 5'd16, 1'b0, 8'h00, 6'd63, 4'd8},  // R8 wiper -> setting 1
      '{24'h5AB400, 5'd24, 1'b1, 8'h3F, 6'd63, 4'd8},  // R8 read back setting 1
      '{24'h6AA005, 5'd24, 1'b0, 8'h00, 6'd63, 4'd2},  // R2 wrong type nibble
      '{24'h5B9000, 5'd24, 1'b0, 8'h00, 6'd63, 4'd13}, // R13 and R2: wrong address read
      '{24'h5AA007, 5'd20, 1'b0, 8'h00, 6'd63, 4'd12}, // R12 truncated write
      '{24'h5AD800, 5'd15, 1'b0, 8'h00, 6'd63, 4'd12}, // R12 truncated transfer
      '{24'h5BC011, 5'd24, 1'b0, 8'h00, 6'd63, 4'd2},  // R2 wrong address write
      '{24'h5AB000, 5'd24, 1'b1, 8'h00, 6'd63, 4'd2},  // R2 setting 0 untouched
      '{24'h5ABC00, 5'd24, 1'b1, 8'h00, 6'd63, 4'd1},  // R1 setting 3 reset value
      '{24'h5A5100, 5'd24, 1'b1, 8'h00, 6'd63, 4'd10}, // R10 idle status
      '{24'h5AA105, 5'd24, 1'b0, 8'h00, 6'd63, 4'd2}   // R2 nonzero low bits
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic [3:0] dev_addr = 4'hA;
   logic       so, so_oe, busy;
   logic [5:0] wiper;

   int checks = 0;
   int errors = 0;
   int run_len = 0;
   int last_len = 0;

   always #4 clk = ~clk;

   dpot_ctrl #(.VAL_W(6), .NUM_DR(4), .ADDR_W(4), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .dev_addr(dev_addr),
      .so(so), .so_oe(so_oe), .wiper(wiper), .busy(busy)
   );

   always @(negedge clk) begin
      if (busy) run_len++;
      else if (run_len != 0) begin
         last_len = run_len;
         run_len  = 0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_bit(input logic b);
      si = b;
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic run_frame(input logic [23:0] f, input int nbits,
                            output logic [7:0] rd, output logic oe_any);
      rd = '0;
      oe_any = 1'b0;
      @(negedge clk) cs_n = 1'b0;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         si = f[23-i];
         repeat (HP) @(negedge clk);
         if (so_oe) oe_any = 1'b1;
         if (i >= 16) rd = {rd[6:0], so};
         sck = 1'b1;
         repeat (HP) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HP) @(negedge clk);
      cs_n = 1'b1;
      si   = 1'b0;
      repeat (HP) @(negedge clk);
   endtask

   task automatic step_frame(input int ups, input int downs);
      @(negedge clk) cs_n = 1'b0;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < 16; i++) pulse_bit(((16'h5A20 >> (15 - i)) & 16'h1) != 0);
      for (int i = 0; i < ups; i++) pulse_bit(1'b1);
      for (int i = 0; i < downs; i++) pulse_bit(1'b0);
      repeat (HP) @(negedge clk);
      cs_n = 1'b1;
      si   = 1'b0;
      repeat (HP) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 10000 && busy; n++) @(negedge clk);
   endtask

   task automatic set_wiper(input logic [5:0] v);
      logic [7:0] rd;
      logic       oe;
      run_frame({16'h5AA0, 2'b00, v}, 24, rd, oe);
      wait_idle();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual 150000 cycles expected fewer");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] rd;
      logic       oe;
      logic [5:0] w0;
      #2 rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: reset state at the ports
      chk("R1 wiper", int'(wiper), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 so_oe", int'(so_oe), 0);

      for (int k = 0; k < NV; k++) begin
         run_frame(VECS[k].frm, int'(VECS[k].nbits), rd, oe);
         wait_idle();
         chk($sformatf("R%0d vec%0d wiper", VECS[k].req, k), int'(wiper), int'(VECS[k].exp_w));
         chk($sformatf("R%0d vec%0d so_oe seen", VECS[k].req, k), int'(oe), int'(VECS[k].chk_rd));
         if (VECS[k].chk_rd)
            chk($sformatf("R%0d vec%0d read byte", VECS[k].req, k), int'(rd), int'(VECS[k].exp_rd));
      end

      // R4, R10, R11: behaviour inside the busy window
      w0 = wiper;
      run_frame(24'h5AC009, 24, rd, oe);
      chk("R4 busy after write", int'(busy), 1);
      run_frame(24'h5A5100, 24, rd, oe);
      chk("R10 status while busy", int'(rd), 1);
      run_frame(24'h5AA011, 24, rd, oe);
      chk("R11 wiper write blocked", int'(wiper), int'(w0));
      run_frame(24'h5AC022, 24, rd, oe);
      run_frame(24'h5AD800, 16, rd, oe);
      chk("R11 transfer blocked", int'(wiper), int'(w0));
      chk("R11 still busy", int'(busy), 1);
      wait_idle();
      repeat (2) @(negedge clk);
      chk("R4 busy length", last_len, BUSY);
      run_frame(24'h5AB000, 24, rd, oe);
      chk("R11 setting 0 kept first value", int'(rd), 9);
      run_frame(24'h5A5100, 24, rd, oe);
      chk("R10 status idle", int'(rd), 0);

      // R9: stepping mode with saturation
      set_wiper(6'd61);
      step_frame(5, 0);
      chk("R9 saturate high", int'(wiper), 63);
      set_wiper(6'd2);
      step_frame(0, 4);
      chk("R9 saturate low", int'(wiper), 0);
      set_wiper(6'd10);
      step_frame(3, 1);
      chk("R9 mixed steps", int'(wiper), 12);
      chk("R9 no busy from steps", int'(busy), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule